// File: doc/BRIEF.md
# Single-Position Shift and Rotate Unit

This unit moves an operand by exactly one bit position, either toward the least significant end or toward the most significant end. A 3-bit operation code selects one of eight variants. Two are logical shifts with a zero fill. Two are arithmetic shifts: the right one copies the sign, and the left one fills with zero. Two are plain rotates. The last two are rotates that pass through a carry bit. Each operation reports the bit that leaves the operand on a carry output. The two rotate-through-carry operations also consume a carry input, and that carry input enters at the vacated end.

Every result is available on two sets of outputs at once. The first set is combinational and follows the inputs within the same cycle. The second set is a registered copy of the result and the carry. It loads only on clock edges where the enable input is high, and it clears under a synchronous active-high reset. A datapath can use the unit in either place: as a pure function inside an execute stage, or as a small accumulator-side shifter that keeps its last result and carry.

Top module: `sr_unit`

## Requirements
- R1: Operation code 000 (logical right) gives {0, opnd[N-1:1]}, and carry-out is opnd[0].
- R2: Operation code 001 (logical left) gives {opnd[N-2:0], 0}, and carry-out is opnd[N-1].
- R3: Operation code 010 (arithmetic right) gives {opnd[N-1], opnd[N-1:1]}, so the sign bit stays in place and is also copied into bit N-2. Carry-out is opnd[0].
- R4: Operation code 011 (arithmetic left) gives the same result and carry-out as code 001.
- R5: Operation code 100 (rotate right) gives {opnd[0], opnd[N-1:1]}, and carry-out is opnd[0].
- R6: Operation code 101 (rotate left) gives {opnd[N-2:0], opnd[N-1]}, and carry-out is opnd[N-1].
- R7: Operation code 110 (rotate right through carry) gives {cin, opnd[N-1:1]}, and carry-out is opnd[0].
- R8: Operation code 111 (rotate left through carry) gives {opnd[N-2:0], cin}, and carry-out is opnd[N-1].
- R9: For operation codes 000 to 101, the carry input has no effect on either the result or the carry-out.
- R10: On a rising clock edge with en high and rst low, res_q and cout_q take the values that res and cout held before that edge.
- R11: On a rising clock edge with en low and rst low, res_q and cout_q keep their values.
- R12: On a rising clock edge with rst high, res_q becomes 0 and cout_q becomes 0, whatever en is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered copy |
| rst | input | 1 | Synchronous active-high reset of the registered copy |
| en | input | 1 | Load enable for the registered copy |
| op | input | 3 | Operation code (000 to 111, see R1 to R8) |
| opnd | input | WIDTH | Operand |
| cin | input | 1 | Carry input |
| res | output | WIDTH | Combinational result |
| cout | output | 1 | Combinational carry-out |
| res_q | output | WIDTH | Registered result |
| cout_q | output | 1 | Registered carry-out |

## Verification
The hardest condition to reach is a registered output that must hold while the combinational result underneath it keeps changing. A hold with a stable input would show nothing. The stimulus therefore walks every operation code over a set of operands, and both carry-in values, with en dropping low on a regular pattern that is not aligned to that walk. During each low-enable cycle the combinational output differs from the stored value. The scoreboard keeps its own copy of the last value that was loaded. Both carry-in values are applied to every non-carry operation, so that any leak of cin into R9's operations shows up as a mismatch.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [2:0] {
        OP_LSR  = 3'b000,
        OP_LSL  = 3'b001,
        OP_ASR  = 3'b010,
        OP_ASL  = 3'b011,
        OP_ROTR = 3'b100,
        OP_ROTL = 3'b101,
        OP_RCR  = 3'b110,
        OP_RCL  = 3'b111
    } sr_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO,
        FILL_SIGN,
        FILL_WRAP,
        FILL_CARRY
    } sr_fill_e;

    typedef struct packed {
        logic     go_right;
        sr_fill_e fill;
    } sr_ctrl_t;

    function automatic sr_ctrl_t sr_decode_op(sr_op_e op);
        sr_ctrl_t c;
        c.go_right = 1'b0;
        c.fill     = FILL_ZERO;
        unique case (op)
            OP_LSR:  begin c.go_right = 1'b1; c.fill = FILL_ZERO;  end
            OP_LSL:  begin c.go_right = 1'b0; c.fill = FILL_ZERO;  end
            OP_ASR:  begin c.go_right = 1'b1; c.fill = FILL_SIGN;  end
            OP_ASL:  begin c.go_right = 1'b0; c.fill = FILL_ZERO;  end
            OP_ROTR: begin c.go_right = 1'b1; c.fill = FILL_WRAP;  end
            OP_ROTL: begin c.go_right = 1'b0; c.fill = FILL_WRAP;  end
            OP_RCR:  begin c.go_right = 1'b1; c.fill = FILL_CARRY; end
            OP_RCL:  begin c.go_right = 1'b0; c.fill = FILL_CARRY; end
            default: begin c.go_right = 1'b0; c.fill = FILL_ZERO;  end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sr_decode.sv
module sr_decode
    import sr_pkg::*;
(
    input  logic [2:0] op,
    output sr_ctrl_t   ctrl
);
    always_comb begin
        ctrl = sr_decode_op(sr_op_e'(op));
    end
endmodule

// File: rtl/sr_datapath.sv
module sr_datapath
    import sr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  sr_ctrl_t         ctrl,
    input  logic [WIDTH-1:0] d,
    input  logic             cin,
    output logic [WIDTH-1:0] y,
    output logic             co
);
    localparam int MSB = WIDTH - 1;

    logic fill_bit;
    logic out_bit;

    // Bit that leaves the operand; it is also the wrap-around bit for rotates.
    always_comb begin
        out_bit = ctrl.go_right ? d[0] : d[MSB];
        unique case (ctrl.fill)
            FILL_ZERO:  fill_bit = 1'b0;
            FILL_SIGN:  fill_bit = d[MSB];
            FILL_WRAP:  fill_bit = out_bit;
            FILL_CARRY: fill_bit = cin;
            default:    fill_bit = 1'b0;
        endcase
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_low
            assign y[i] = ctrl.go_right ? d[i+1] : fill_bit;
        end else if (i == MSB) begin : g_high
            assign y[i] = ctrl.go_right ? fill_bit : d[i-1];
        end else begin : g_mid
            assign y[i] = ctrl.go_right ? d[i+1] : d[i-1];
        end
    end

    assign co = out_bit;
endmodule

// File: rtl/sr_hold.sv
module sr_hold #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] y_in,
    input  logic             co_in,
    output logic [WIDTH-1:0] y_q,
    output logic             co_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            y_q  <= '0;
            co_q <= 1'b0;
        end else if (en) begin
            y_q  <= y_in;
            co_q <= co_in;
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(y_q) && $stable(co_q))); // R11

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (y_q == '0 && co_q == 1'b0)); // R12
endmodule

// File: rtl/sr_unit.sv
module sr_unit
    import sr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] opnd,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic [WIDTH-1:0] res_q,
    output logic             cout_q
);
    localparam int MSB = WIDTH - 1;

    sr_ctrl_t ctrl;

    sr_decode u_decode (
        .op   (op),
        .ctrl (ctrl)
    );

    sr_datapath #(.WIDTH(WIDTH)) u_path (
        .ctrl (ctrl),
        .d    (opnd),
        .cin  (cin),
        .y    (res),
        .co   (cout)
    );

    sr_hold #(.WIDTH(WIDTH)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .y_in  (res),
        .co_in (cout),
        .y_q   (res_q),
        .co_q  (cout_q)
    );

    AST_LSR_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b000) |-> (res[MSB] == 1'b0 && cout == opnd[0])); // R1

    AST_LSL_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b001) |-> (res[0] == 1'b0 && cout == opnd[MSB])); // R2

    AST_ASR_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b010) |-> (res[MSB] == opnd[MSB] && res[MSB-1] == opnd[MSB])); // R3

    AST_ROTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b100) |-> (res[MSB] == opnd[0] && cout == opnd[0])); // R5

    AST_RCR_CARRY_PATH: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b110) |-> (res[MSB] == cin && cout == opnd[0])); // R7

    AST_RCL_CARRY_PATH: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b111) |-> (res[0] == cin && cout == opnd[MSB])); // R8

    AST_LOAD_ON_EN: assert property (@(posedge clk) disable iff (rst)
        en |=> (res_q == $past(res) && cout_q == $past(cout))); // R10
endmodule

// File: tb/tb_sr_unit.sv
module tb_sr_unit;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic [2:0]   op = 3'b000;
    logic [W-1:0] opnd = '0;
    logic         cin = 1'b0;
    logic [W-1:0] res, res_q;
    logic         cout, cout_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W-1:0] y;
        logic         co;
        logic [W-1:0] yq;
        logic         coq;
        int           ctag;
        int           rtag;
    } item_t;

    item_t sb[$];
    logic [W-1:0] held_y = '0;
    logic         held_co = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_unit #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .en(en), .op(op), .opnd(opnd), .cin(cin),
        .res(res), .cout(cout), .res_q(res_q), .cout_q(cout_q)
    );

    // Model written from R1..R8; returns {carry, result}.
    function automatic logic [W:0] model(input logic [2:0] o, input logic [W-1:0] d, input logic c);
        case (o)
            3'b000: return {d[0],   1'b0,   d[W-1:1]};   // R1
            3'b001: return {d[W-1], d[W-2:0], 1'b0};     // R2
            3'b010: return {d[0],   d[W-1], d[W-1:1]};   // R3
            3'b011: return {d[W-1], d[W-2:0], 1'b0};     // R4
            3'b100: return {d[0],   d[0],   d[W-1:1]};   // R5
            3'b101: return {d[W-1], d[W-2:0], d[W-1]};   // R6
            3'b110: return {d[0],   c,      d[W-1:1]};   // R7
            default: return {d[W-1], d[W-2:0], c};       // R8
        endcase
    endfunction

    task automatic check(input int tag, input logic [W:0] act, input logic [W:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one vector at the falling edge and pushes what it expects.
    task automatic drive(input logic [2:0] o, input logic [W-1:0] d, input logic c, input logic e, input int tag);
        item_t it;
        logic [W:0] m;
        @(negedge clk);
        op = o; opnd = d; cin = c; en = e;
        m = model(o, d, c);
        if (e) begin
            held_y  = m[W-1:0];
            held_co = m[W];
        end
        it.y = m[W-1:0]; it.co = m[W];
        it.yq = held_y; it.coq = held_co;
        it.ctag = tag;
        it.rtag = e ? 10 : 11; // R10 load, R11 hold
        sb.push_back(it);
    endtask

    // Monitor: after each rising edge, compare both output sets with the oldest item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.ctag, {cout, res},     {it.co, it.y},   "combinational");
                check(it.rtag, {cout_q, res_q}, {it.coq, it.yq}, "registered");
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pat;
        int step;
        // R12: reset clears the registered copy even with en high
        en = 1'b1; opnd = 8'hFF; op = 3'b101;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(12, {cout_q, res_q}, {1'b0, 8'h00}, "reset state");
        rst = 1'b0;
        en = 1'b0;

        // Worked examples on 11001100 with carry 0, one per operation
        drive(3'b000, 8'hCC, 1'b0, 1'b1, 1);  // R1 -> 66, c0
        drive(3'b001, 8'hCC, 1'b0, 1'b1, 2);  // R2 -> 98, c1
        drive(3'b010, 8'hCC, 1'b0, 1'b1, 3);  // R3 -> E6, c0
        drive(3'b011, 8'hCC, 1'b0, 1'b1, 4);  // R4 -> 98, c1
        drive(3'b100, 8'hCC, 1'b0, 1'b1, 5);  // R5 -> 66, c0
        drive(3'b101, 8'hCC, 1'b0, 1'b1, 6);  // R6 -> 99, c1
        drive(3'b110, 8'hCC, 1'b0, 1'b1, 7);  // R7 -> 66, c0
        drive(3'b111, 8'hCC, 1'b0, 1'b1, 8);  // R8 -> 98, c1
        drive(3'b110, 8'hCC, 1'b1, 1'b1, 7);  // R7 with carry 1 -> E6
        drive(3'b111, 8'hCC, 1'b1, 1'b1, 8);  // R8 with carry 1 -> 99

        // R9: carry-in set on every non-carry operation
        for (int o = 0; o < 6; o++) begin
            drive(3'(o), 8'hCC, 1'b1, 1'b1, 9);
            drive(3'(o), 8'h81, 1'b1, 1'b1, 9);
        end

        // Sweep with en dropping low on a pattern unrelated to the op walk (R10, R11)
        pat = 8'h01;
        step = 0;
        for (int k = 0; k < 24; k++) begin
            for (int o = 0; o < 8; o++) begin
                for (int c = 0; c < 2; c++) begin
                    drive(3'(o), pat, 1'(c), (step % 5) != 2 && (step % 7) != 4, o + 1);
                    step++;
                end
            end
            pat = {pat[W-2:0], pat[W-1] ^ pat[5] ^ pat[4] ^ pat[3]} ^ 8'(k * 37);
        end

        // Boundary operands
        drive(3'b010, 8'h80, 1'b0, 1'b1, 3);  // R3 negative minimum
        drive(3'b010, 8'h7F, 1'b1, 1'b0, 3);  // R3 positive, hold (R11)
        drive(3'b000, 8'hFF, 1'b1, 1'b0, 1);  // R1 all ones, hold (R11)
        drive(3'b101, 8'h00, 1'b1, 1'b1, 6);  // R6 zero operand
        drive(3'b111, 8'h00, 1'b1, 1'b1, 8);  // R8 carry alone survives

        @(posedge clk);
        #2;
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule